// File: doc/BRIEF.md
# PWM Timer with Conversion Trigger

This block is a 16-bit up counter with three compare channels. One channel requests a conversion, one sets a PWM pin, and one closes the PWM period. While the block is running, the counter steps up by one each clock. When the count equals the cycle value, the counter reloads to one, so the period is the cycle value in clocks. When the count equals the duty value, the pin goes to its active (high) level. When the count equals the cycle value, the pin goes back to its start (low) level. When the count equals the trigger value, the block sends a one-clock conversion request to an external converter.

Each channel has a sticky status flag and an interrupt enable. Software clears the flags through a per-channel clear strobe. All compare values and the control word can be written through a simple write port while the timer runs, and a written value takes effect on the next clock.

The pin is driven by a three-state machine:

- `PIN_IDLE`: the timer is stopped and the pin is low.
- `PIN_LEAD`: the pin is low before the duty match.
- `PIN_TRAIL`: the pin is high after the duty match.

The state machine has four transitions:

- **START**: `PIN_IDLE` goes to `PIN_LEAD` once the timer runs.
- **DUTY**: the state goes to `PIN_TRAIL` on a duty match with no cycle match.
- **CYCLE**: the state goes to `PIN_LEAD` on a cycle match, from any running state.
- **STOP**: any state goes to `PIN_IDLE` while the run bit is clear.

Top module: `pwm_trig_timer`

## Requirements
- R1: After reset the outputs are as follows: `count_o` is 0, `pwm_out` is low, `flags` is 0, `irq` is 0 and `conv_req` is 0. The timer is stopped with all interrupt enables off.
- R2: While the run bit is set and no cycle match occurs, `count_o` rises by one each clock and wraps from 0xFFFF to 0.
- R3: On a running clock where the count equals the cycle value (address 2), the next count is 1, flag bit 2 is set and `pwm_out` is low.
- R4: On a running clock where the count equals the duty value (address 1) and not the cycle value, flag bit 1 is set and `pwm_out` is high from the next clock.
- R5: When the duty and cycle matches happen on the same clock, the cycle match takes priority: the pin goes low and the counter reloads to 1.
- R6: On a running clock where the count equals the trigger value (address 0), flag bit 0 is set and `conv_req` is high for the following clock only. `conv_req` is low after any clock without a trigger match.
- R7: `irq[i]` is high exactly when flag bit i and interrupt enable i are both set. The enables are control bits 3:1 for trigger, duty and cycle, in that order.
- R8: Writing a 1 to `flag_clr[i]` clears flag bit i on the next clock, unless channel i matches on that same clock, in which case the flag stays set.
- R9: Compare writes take effect on the next clock. If the cycle value is lowered below the current count, the counter runs on to 0xFFFF, wraps to 0 and then reloads at the new value.
- R10: While the run bit (control bit 0, address 3) is clear, the count holds, no flag is set and `pwm_out` is low from the clock after the stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 trigger, 1 duty, 2 cycle, 3 control |
| wr_data | input | 16 | Write data; control uses bit 0 as run and bits 3:1 as enables |
| flag_clr | input | 3 | Per-flag clear strobe (bit 0 trigger, 1 duty, 2 cycle) |
| count_o | output | 16 | Current counter value |
| pwm_out | output | 1 | PWM pin level |
| conv_req | output | 1 | One-clock conversion start request |
| flags | output | 3 | Sticky match flags (trigger, duty, cycle) |
| irq | output | 3 | Interrupt lines, each a flag gated by its enable |

## Verification
The assertions assume the following about the inputs:

- Reset is held for at least one clock before any property is evaluated.
- Writes and clear strobes are single-clock pulses that are sampled at the same edge as the match logic.

The stimulus keeps within these assumptions. All writes and strobes are driven one nanosecond after a rising edge and are dropped after the next edge. Compare values are reprogrammed only through the write port, during stops or at clock boundaries chosen by the sweep. The bench keeps a cycle-accurate arithmetic model of the count, pin, flags and request. It sweeps every duty and cycle pair in a small range, with periodic clear strobes that sometimes coincide with matches.

// File: rtl/pwm_trig_pkg.sv
`timescale 1ns/1ps
package pwm_trig_pkg;
    localparam int NUM_CH  = 3;
    localparam int CH_TRIG = 0;
    localparam int CH_DUTY = 1;
    localparam int CH_CYC  = 2;
    localparam int ADDR_W  = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'd0,
        PIN_LEAD  = 2'd1,
        PIN_TRAIL = 2'd2
    } pin_state_t;
endpackage

// File: rtl/pwm_cnt.sv
`timescale 1ns/1ps
module pwm_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] RELOAD_VAL = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (reload)
            count <= RELOAD_VAL;
        else if (run)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/pwm_match.sv
`timescale 1ns/1ps
module pwm_match #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val [N_CH],
    input  logic [N_CH-1:0]  clr,
    output logic [N_CH-1:0]  hit,
    output logic [N_CH-1:0]  flag
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        assign hit[ch] = run && (count == cmp_val[ch]);

        always_ff @(posedge clk) begin
            if (!rst_n)
                flag[ch] <= 1'b0;
            else
                flag[ch] <= hit[ch] | (flag[ch] & ~clr[ch]);
        end
    end
endmodule

// File: rtl/pwm_pin_fsm.sv
`timescale 1ns/1ps
module pwm_pin_fsm
    import pwm_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic duty_hit,
    input  logic cyc_hit,
    output logic pin
);
    pin_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PIN_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = PIN_IDLE;                // STOP
        end else if (cyc_hit) begin
            state_d = PIN_LEAD;                // CYCLE (wins over duty)
        end else if (duty_hit) begin
            state_d = PIN_TRAIL;               // DUTY
        end else begin
            unique case (state_q)
                PIN_IDLE:  state_d = PIN_LEAD; // START
                PIN_LEAD:  state_d = PIN_LEAD;
                PIN_TRAIL: state_d = PIN_TRAIL;
                default:   state_d = PIN_IDLE;
            endcase
        end
    end

    always_comb begin
        pin = (state_q == PIN_TRAIL);
    end
endmodule

// File: rtl/pwm_trig_timer.sv
`timescale 1ns/1ps
module pwm_trig_timer
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] flag_clr,
    output logic [CNT_W-1:0]  count_o,
    output logic              pwm_out,
    output logic              conv_req,
    output logic [NUM_CH-1:0] flags,
    output logic [NUM_CH-1:0] irq
);
    logic [CNT_W-1:0]  cmp_q [NUM_CH];
    logic              run_q;
    logic [NUM_CH-1:0] ie_q;
    logic [NUM_CH-1:0] hit;
    logic              conv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) cmp_q[i] <= '1;
            run_q <= 1'b0;
            ie_q  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++)
                if (wr_addr == ADDR_W'(i)) cmp_q[i] <= wr_data;
            if (wr_addr == ADDR_CTRL) begin
                run_q <= wr_data[0];
                ie_q  <= wr_data[NUM_CH:1];
            end
        end
    end

    pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .reload (hit[CH_CYC]),
        .count  (count_o)
    );

    pwm_match #(.CNT_W(CNT_W), .N_CH(NUM_CH)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .count   (count_o),
        .cmp_val (cmp_q),
        .clr     (flag_clr),
        .hit     (hit),
        .flag    (flags)
    );

    pwm_pin_fsm u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .duty_hit (hit[CH_DUTY]),
        .cyc_hit  (hit[CH_CYC]),
        .pin      (pwm_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            conv_q <= 1'b0;
        else
            conv_q <= hit[CH_TRIG];
    end

    assign conv_req = conv_q;
    assign irq      = flags & ie_q;
endmodule

// File: rtl/pwm_trig_timer_chk.sv
`timescale 1ns/1ps
module pwm_trig_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] trig_val,
    input logic [CNT_W-1:0] duty_val,
    input logic [CNT_W-1:0] cyc_val,
    input logic [2:0]       flag_clr,
    input logic [2:0]       flags,
    input logic [2:0]       irq,
    input logic             pwm_out,
    input logic             conv_req
);
    logic t_eq, d_eq, c_eq;
    assign t_eq = run && (count == trig_val);
    assign d_eq = run && (count == duty_val);
    assign c_eq = run && (count == cyc_val);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !c_eq |=> count == CNT_W'($past(count) + CNT_W'(1))); // R2
    AST_RELOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        c_eq |=> count == CNT_W'(1)); // R3
    AST_CYC_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        c_eq |=> !pwm_out && flags[2]); // R5
    AST_DUTY_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        d_eq && !c_eq |=> pwm_out && flags[1]); // R4
    AST_CONV_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        t_eq |=> conv_req && flags[0]); // R6
    AST_CONV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !t_eq |=> !conv_req); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~flags) == 3'b000); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)); // R8
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && flag_clr == 3'b000 |=> $stable(flags) && $stable(count)); // R10
endmodule

bind pwm_trig_timer pwm_trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .count    (count_o),
    .trig_val (cmp_q[0]),
    .duty_val (cmp_q[1]),
    .cyc_val  (cmp_q[2]),
    .flag_clr (flag_clr),
    .flags    (flags),
    .irq      (irq),
    .pwm_out  (pwm_out),
    .conv_req (conv_req)
);

// File: tb/pwm_trig_timer_bench.sv
`timescale 1ns/1ps
module pwm_trig_timer_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [1:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic [2:0]   flag_clr;
    logic [W-1:0] count_o;
    logic         pwm_out, conv_req;
    logic [2:0]   flags, irq;

    always #4 clk = ~clk;

    pwm_trig_timer #(.CNT_W(W)) u_pwm_trig_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_clr(flag_clr), .count_o(count_o),
        .pwm_out(pwm_out), .conv_req(conv_req), .flags(flags), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_cnt;
    logic [W-1:0] m_cmp [3];
    logic         m_run, m_pin, m_conv;
    logic [2:0]   m_ie, m_flags;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; flag_clr = '0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_cnt = '0; m_run = 1'b0; m_ie = '0; m_flags = '0; m_pin = 1'b0; m_conv = 1'b0;
        for (int i = 0; i < 3; i++) m_cmp[i] = '1;
    endtask

    task automatic step(input logic [2:0] clr, input bit we, input logic [1:0] a,
                        input logic [W-1:0] d, input bit check);
        logic [2:0] hit;
        flag_clr = clr; wr_en = we; wr_addr = a; wr_data = d;
        for (int i = 0; i < 3; i++) hit[i] = m_run && (m_cnt == m_cmp[i]);
        m_conv  = hit[0];
        m_flags = hit | (m_flags & ~clr);
        m_pin   = !m_run ? 1'b0 : hit[2] ? 1'b0 : hit[1] ? 1'b1 : m_pin;
        if (hit[2]) m_cnt = W'(1);
        else if (m_run) m_cnt = m_cnt + W'(1);
        if (we) begin
            if (a == 2'd3) begin m_run = d[0]; m_ie = d[3:1]; end
            else m_cmp[a] = d;
        end
        @(posedge clk);
        #1;
        flag_clr = '0; wr_en = 1'b0;
        if (check) begin
            chk("R2", "count", 32'(count_o), 32'(m_cnt));
            chk("R4", "pwm_out", 32'(pwm_out), 32'(m_pin));
            chk("R3", "flags", 32'(flags), 32'(m_flags));
            chk("R6", "conv_req", 32'(conv_req), 32'(m_conv));
            chk("R7", "irq", 32'(irq), 32'(m_flags & m_ie));
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        step(3'b000, 1'b1, a, d, 1'b1);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "count", 32'(count_o), 32'h0);
        chk("R1", "pwm_out", 32'(pwm_out), 32'h0);
        chk("R1", "flags", 32'(flags), 32'h0);
        chk("R1", "irq", 32'(irq), 32'h0);
        chk("R1", "conv_req", 32'(conv_req), 32'h0);

        // Sweep of duty/cycle pairs: R3 R4 R5 R6 R7 R8 R10
        for (int cy = 1; cy <= 6; cy++) begin
            for (int du = 1; du <= 7; du++) begin
                do_reset();
                wr(2'd0, W'(2));
                wr(2'd1, W'(du));
                wr(2'd2, W'(cy));
                wr(2'd3, W'((du + cy) % 8 * 2 + 1));
                for (int k = 0; k < 3 * cy + 6; k++)
                    step((k % 5 == 3) ? 3'b111 : 3'b000, 1'b0, 2'd0, '0, 1'b1);
                wr(2'd3, W'(14));  // stop, enables on (R10)
                for (int k = 0; k < 3; k++) step(3'b000, 1'b0, 2'd0, '0, 1'b1);
                chk("R10", "pin low when stopped", 32'(pwm_out), 32'h0);
            end
        end

        // R5 directed: duty equals cycle
        do_reset();
        wr(2'd1, W'(3)); wr(2'd2, W'(3)); wr(2'd3, W'(1));
        while (m_cnt != W'(3)) step(3'b000, 1'b0, 2'd0, '0, 1'b1);
        step(3'b000, 1'b0, 2'd0, '0, 1'b1);
        chk("R5", "pin after joint match", 32'(pwm_out), 32'h0);
        chk("R5", "count after joint match", 32'(count_o), 32'h1);

        // R8 directed: clear coinciding with a match, then a plain clear
        do_reset();
        wr(2'd0, W'(3)); wr(2'd1, W'(2)); wr(2'd2, W'(4)); wr(2'd3, W'(1));
        while (m_cnt != W'(4)) step(3'b000, 1'b0, 2'd0, '0, 1'b1);
        step(3'b100, 1'b0, 2'd0, '0, 1'b1);
        chk("R8", "cycle flag kept on coincident clear", 32'(flags[2]), 32'h1);
        step(3'b100, 1'b0, 2'd0, '0, 1'b1);
        chk("R8", "cycle flag cleared", 32'(flags[2]), 32'h0);

        // R9 directed: cycle lowered below the count
        do_reset();
        wr(2'd1, W'(5)); wr(2'd2, W'(10)); wr(2'd3, W'(1));
        while (m_cnt != W'(8)) step(3'b000, 1'b0, 2'd0, '0, 1'b1);
        wr(2'd2, W'(3));
        while (m_cnt != W'('1)) step(3'b000, 1'b0, 2'd0, '0, 1'b0);
        chk("R9", "count reached top", 32'(count_o), 32'hFFFF);
        chk("R9", "no cycle flag before wrap", 32'(flags[2]), 32'h0);
        step(3'b000, 1'b0, 2'd0, '0, 1'b1);
        chk("R9", "count wrapped", 32'(count_o), 32'h0);
        for (int k = 0; k < 4; k++) step(3'b000, 1'b0, 2'd0, '0, 1'b1);
        chk("R9", "reload at new cycle", 32'(count_o), 32'h1);
        chk("R9", "cycle flag after wrap", 32'(flags[2]), 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(64'd8 * 64'd190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule